// File: doc/BRIEF.md
# Two-wire serial memory slave engine

This block is the slave side of a two-wire serial byte memory. It watches an SCL and SDA line pair that has already been synchronised into a fast system clock domain. It finds start and stop conditions and checks the device address byte. For writes it takes a two-byte word address and passes each received data byte, with its address, to a separate page-write committer. For reads it fetches bytes from a 32K x 8 array through a combinational read port and shifts them out. The block drives the bus only through an active-low output enable, so a one on the line is always a released line.

A word-address pointer persists across transactions and always holds the address after the last byte touched. A read header with no address phase therefore returns the next byte in order. A write header followed by a repeated start and a read header gives a random read. Write addresses roll over inside a 64-byte page. Read addresses roll over across the whole array. While the committer reports a write in progress, the engine refuses every device address.

Top module: `ser_eeprom_slave`

## Requirements
- R1: A start is SDA falling while SCL stays high; a stop is SDA rising while SCL stays high. A stop releases SDA and returns the engine to idle, and a stop in the middle of a byte discards that byte, so no write is issued.
- R2: The first byte after a start is the device address, sent MSB first. Bits 7..1 must equal 1010000 and bit 0 selects the operation (1 read, 0 write). On a match the engine pulls SDA low through the ninth clock. On any other value it leaves SDA released and ignores every later byte until the next start.
- R3: While `wr_busy` is high, a device address is never acknowledged, even when it matches.
- R4: A write header is followed by a high and a low address byte, each acknowledged. The pointer loads the low ADDR_W bits of {high, low}, so with ADDR_W = 15 bit 7 of the high byte is ignored. Each data byte is acknowledged and shows up as a one-cycle `wr_valid` pulse carrying `wr_addr` and `wr_data`.
- R5: During a write, only the low PAGE_W (6) pointer bits step after each data byte. Address 0x013F is followed by 0x0100.
- R6: A read header with no address phase returns the byte at the pointer. The pointer holds the last accessed address plus one and keeps that value across transactions.
- R7: A write header with its two address bytes, followed by a repeated start and a read header, returns the byte at the loaded address.
- R8: In a read, a master acknowledge (SDA low in the ninth clock) steps the pointer and starts the next byte. Address 0x7FFF is followed by 0x0000.
- R9: A master not-acknowledge ends the read: SDA stays released and the pointer is left at the last byte sent plus one.
- R10: The engine changes its SDA drive only while SCL is low, and read bits hold steady for the whole SCL high time.
- R11: A start in the middle of a byte aborts the transaction without a write and waits for a new device address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised serial clock line |
| sda_i | input | 1 | Synchronised serial data line (wired value) |
| wr_busy | input | 1 | Committer is writing; refuse device addresses |
| sda_oe | output | 1 | Pull SDA low when 1 |
| mem_rd_addr | output | ADDR_W | Array read address (the current pointer) |
| mem_rd_data | input | 8 | Array read data, combinational from mem_rd_addr |
| wr_valid | output | 1 | One-cycle pulse: a data byte was received |
| wr_addr | output | ADDR_W | Array address of that byte |
| wr_data | output | 8 | The received data byte |

## Verification
A corrupted bit counter or state shows up within one byte time as an acknowledge in the wrong clock or a missing one, or as read bits shifted by a position. A wrong pointer stays hidden until the next read without an address phase or the next write pulse, and then it shows up as a wrong byte or a wrong `wr_addr`. Faults in the page or array wraparound appear only at 0x..3F and at 0x7FFF, so those addresses are driven on purpose. An SDA drive that changes while SCL is high corrupts the read byte that the master samples.

// File: rtl/ee_pkg.sv
package ee_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_RACK
  } ee_state_t;

  localparam logic [6:0] DEV_ID = 7'b1010000;
  localparam logic [3:0] BYTE_BITS = 4'd8;

  // Device byte carries the 7-bit id above the read/write flag.
  function automatic logic dev_match(input logic [7:0] b);
    return b[7:1] == DEV_ID;
  endfunction

  // Step only the low pw bits, keep the page number.
  function automatic logic [15:0] page_next(input logic [15:0] a, input int unsigned pw);
    logic [15:0] m;
    m = (16'h1 << pw) - 16'h1;
    return (a & ~m) | ((a + 16'h1) & m);
  endfunction

  // Step across the whole aw-bit space, wrapping to zero.
  function automatic logic [15:0] seq_next(input logic [15:0] a, input int unsigned aw);
    logic [15:0] m;
    m = (aw >= 16) ? 16'hFFFF : ((16'h1 << aw) - 16'h1);
    return (a + 16'h1) & m;
  endfunction

endpackage

// File: rtl/ee_bus_events.sv
module ee_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_evt,
  output logic stop_evt,
  output logic rise_evt,
  output logic fall_evt
);
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // SDA edges count as conditions only when SCL is high on both samples.
  assign start_evt = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_evt  = scl_q & scl_i & ~sda_q & sda_i;
  assign rise_evt  = ~scl_q & scl_i;
  assign fall_evt  = scl_q & ~scl_i;
endmodule

// File: rtl/ee_addr_ptr.sv
module ee_addr_ptr #(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step_page,
  input  logic              step_seq,
  output logic [ADDR_W-1:0] ptr
);
  import ee_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (load_en) begin
      ptr <= load_val;
    end else if (step_page) begin
      ptr <= ADDR_W'(page_next(16'(ptr), PAGE_W));
    end else if (step_seq) begin
      ptr <= ADDR_W'(seq_next(16'(ptr), ADDR_W));
    end
  end
endmodule

// File: rtl/ser_eeprom_slave.sv
module ser_eeprom_slave #(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              wr_busy,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  import ee_pkg::*;

  ee_state_t         state_q;
  logic [3:0]        bit_cnt_q;
  logic              ack_slot_q;
  logic [7:0]        rx_sh_q;
  logic [7:0]        tx_sh_q;
  logic [7:0]        hi_q;
  logic              rw_q;
  logic              macked_q;
  logic [ADDR_W-1:0] ptr;

  // Named internal events, also watched by the checker.
  logic start_evt, stop_evt, rise_evt, fall_evt;
  logic rx_state, byte_eval, dev_eval, dev_hit, ack_end, tx_done;
  logic load_en, step_page;
  logic [ADDR_W-1:0] load_val;

  ee_bus_events u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  assign rx_state  = (state_q == ST_DEV) || (state_q == ST_AHI) ||
                     (state_q == ST_ALO) || (state_q == ST_WDAT);
  assign byte_eval = rx_state && fall_evt && (bit_cnt_q == BYTE_BITS) && !ack_slot_q;
  assign dev_eval  = byte_eval && (state_q == ST_DEV);
  assign dev_hit   = dev_match(rx_sh_q) && !wr_busy;
  assign ack_end   = rx_state && fall_evt && ack_slot_q;
  assign tx_done   = (state_q == ST_RDAT) && fall_evt && (bit_cnt_q == BYTE_BITS);
  assign load_en   = byte_eval && (state_q == ST_ALO);
  assign step_page = byte_eval && (state_q == ST_WDAT);
  assign load_val  = ADDR_W'({hi_q, rx_sh_q});

  ee_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .load_val (load_val),
    .step_page(step_page),
    .step_seq (tx_done),
    .ptr      (ptr)
  );

  assign mem_rd_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= step_page;
      if (step_page) begin
        wr_addr <= ptr;
        wr_data <= rx_sh_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      ack_slot_q <= 1'b0;
      rx_sh_q    <= '0;
      tx_sh_q    <= '0;
      hi_q       <= '0;
      rw_q       <= 1'b0;
      macked_q   <= 1'b0;
      sda_oe     <= 1'b0;
    end else if (start_evt) begin
      state_q    <= ST_DEV;
      bit_cnt_q  <= '0;
      ack_slot_q <= 1'b0;
      sda_oe     <= 1'b0;
    end else if (stop_evt) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      ack_slot_q <= 1'b0;
      sda_oe     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
          if (rise_evt && !ack_slot_q && (bit_cnt_q < BYTE_BITS)) begin
            rx_sh_q   <= {rx_sh_q[6:0], sda_i};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_eval) begin
            if ((state_q == ST_DEV) && !dev_hit) begin
              state_q   <= ST_IDLE;
              bit_cnt_q <= '0;
              sda_oe    <= 1'b0;
            end else begin
              ack_slot_q <= 1'b1;
              sda_oe     <= 1'b1;
              if (state_q == ST_DEV) rw_q <= rx_sh_q[0];
              if (state_q == ST_AHI) hi_q <= rx_sh_q;
            end
          end else if (ack_end) begin
            ack_slot_q <= 1'b0;
            bit_cnt_q  <= '0;
            sda_oe     <= 1'b0;
            unique case (state_q)
              ST_DEV: begin
                if (rw_q) begin
                  state_q <= ST_RDAT;
                  tx_sh_q <= mem_rd_data;
                  sda_oe  <= ~mem_rd_data[7];
                end else begin
                  state_q <= ST_AHI;
                end
              end
              ST_AHI:  state_q <= ST_ALO;
              default: state_q <= ST_WDAT;
            endcase
          end
        end
        ST_RDAT: begin
          if (rise_evt && (bit_cnt_q < BYTE_BITS)) begin
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (fall_evt) begin
            if (bit_cnt_q == BYTE_BITS) begin
              sda_oe  <= 1'b0;
              state_q <= ST_RACK;
            end else if (bit_cnt_q != 4'd0) begin
              tx_sh_q <= {tx_sh_q[6:0], 1'b0};
              sda_oe  <= ~tx_sh_q[6];
            end
          end
        end
        ST_RACK: begin
          if (rise_evt) begin
            macked_q <= ~sda_i;
          end else if (fall_evt) begin
            bit_cnt_q <= '0;
            if (macked_q) begin
              state_q <= ST_RDAT;
              tx_sh_q <= mem_rd_data;
              sda_oe  <= ~mem_rd_data[7];
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ee_slave_checker.sv
module ee_slave_checker #(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              wr_busy,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              dev_eval
);
  logic              seen_q;
  logic [ADDR_W-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (start_evt) begin
      seen_q <= 1'b0;
    end else if (wr_valid) begin
      seen_q <= 1'b1;
      last_q <= wr_addr;
    end
  end

  AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!$past(scl_i) || $past(start_evt) || $past(stop_evt))); // R10

  AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_eval && wr_busy) |=> !sda_oe); // R3

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe); // R1

  AST_START_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (!sda_oe && !wr_valid)); // R11

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid); // R4

  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && seen_q) |->
      ((wr_addr[ADDR_W-1:PAGE_W] == last_q[ADDR_W-1:PAGE_W]) &&
       (wr_addr[PAGE_W-1:0] == PAGE_W'(last_q[PAGE_W-1:0] + 1'b1)))); // R5
endmodule

bind ser_eeprom_slave ee_slave_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe),
  .wr_busy  (wr_busy),
  .wr_valid (wr_valid),
  .wr_addr  (wr_addr),
  .start_evt(start_evt),
  .stop_evt (stop_evt),
  .dev_eval (dev_eval)
);

// File: tb/ser_eeprom_slave_test.sv
module ser_eeprom_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 4;
  localparam int AW = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wr_busy = 1'b0;
  logic sda_oe, wr_valid;
  logic [AW-1:0] mem_rd_addr, wr_addr;
  logic [7:0] mem_rd_data, wr_data;
  logic sda_line;

  int n_checks = 0;
  int n_errs = 0;
  int wr_cnt = 0;
  logic [AW-1:0] wr_log_a [0:63];
  logic [7:0]    wr_log_d [0:63];
  logic [7:0]    wmap [int];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  ser_eeprom_slave #(.ADDR_W(AW), .PAGE_W(6)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .wr_busy(wr_busy),
    .sda_oe(sda_oe), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic [7:0] fill(input logic [AW-1:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] model_rd(input logic [AW-1:0] a, input int gen);
    if (gen >= 0 && wmap.exists(int'(a))) return wmap[int'(a)];
    return fill(a);
  endfunction

  assign mem_rd_data = model_rd(mem_rd_addr, wr_cnt);

  always @(posedge clk) begin
    if (wr_valid) begin
      wmap[int'(wr_addr)] = wr_data;
      wr_log_a[wr_cnt[5:0]] = wr_addr;
      wr_log_d[wr_cnt[5:0]] = wr_data;
      wr_cnt = wr_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qwait();
    scl_m = 1'b1; qwait(); qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    ack = ~sda_line; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d, output bit steady);
    logic a, b;
    steady = 1;
    d = '0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      qwait();
      scl_m = 1'b1; qwait();
      a = sda_line; qwait();
      b = sda_line;
      scl_m = 1'b0;
      d = {d[6:0], a};
      if (a != b) steady = 0;
    end
    qwait();
    sda_m = ~mack;
    scl_m = 1'b1; qwait(); qwait();
    scl_m = 1'b0; qwait();
    sda_m = 1'b1;
  endtask

  task automatic write_hdr(input logic [7:0] hi, input logic [7:0] lo, output bit ok);
    bit a0, a1, a2;
    bus_start();
    send_byte(8'hA0, a0);
    send_byte(hi, a1);
    send_byte(lo, a2);
    ok = a0 & a1 & a2;
  endtask

  task automatic read_one(output logic [7:0] d, output bit ack, output bit steady);
    bus_start();
    send_byte(8'hA1, ack);
    recv_byte(1'b0, d, steady);
  endtask

  typedef struct packed {
    logic [7:0]    hi;
    logic [7:0]    lo;
    logic [7:0]    dat;
    logic [AW-1:0] eaddr;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'h00, 8'h10, 8'hC3, 15'h0010},
    '{8'h12, 8'h34, 8'h00, 15'h1234},
    '{8'h80, 8'h05, 8'hFF, 15'h0005},
    '{8'h7F, 8'hFF, 8'h96, 15'h7FFF},
    '{8'hFF, 8'hC0, 8'h3C, 15'h7FC0},
    '{8'h2A, 8'hAA, 8'h81, 15'h2AAA}
  };

  initial begin
    bit ok, ack, st;
    logic [7:0] d;
    int base;
    logic [AW-1:0] nxt;

    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0 && wr_valid == 1'b0, "R1 reset released", {sda_oe, wr_valid}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Table: byte write, random read back, then read with no address phase.
    foreach (VECS[k]) begin
      base = wr_cnt;
      write_hdr(VECS[k].hi, VECS[k].lo, ok);
      send_byte(VECS[k].dat, ack);
      bus_stop();
      chk(ok && ack, "R4 header and data acked", {ok, ack}, 3);
      chk(wr_cnt == base + 1 && wr_log_a[base[5:0]] == VECS[k].eaddr,
          "R4 write address", int'(wr_log_a[base[5:0]]), int'(VECS[k].eaddr));
      chk(wr_log_d[base[5:0]] == VECS[k].dat, "R4 write data",
          int'(wr_log_d[base[5:0]]), int'(VECS[k].dat));
      write_hdr(VECS[k].hi, VECS[k].lo, ok);
      read_one(d, ack, st);
      chk(d == VECS[k].dat, "R7 random read", int'(d), int'(VECS[k].dat));
      chk(st, "R10 read bits steady", int'(st), 1);
      chk(sda_line == 1'b1, "R9 released after nack", int'(sda_line), 1);
      bus_stop();
      nxt = VECS[k].eaddr + 1'b1;
      read_one(d, ack, st);
      bus_stop();
      chk(ack && d == model_rd(nxt, 0), "R6,R9 current read at last+1",
          int'(d), int'(model_rd(nxt, 0)));
    end

    // Mismatched device bytes: no ack, later bytes ignored, pointer kept.
    base = wr_cnt;
    bus_start();
    send_byte(8'hA8, ack);
    chk(!ack, "R2 bad id 0xA8 not acked", int'(ack), 0);
    send_byte(8'h00, ack); send_byte(8'h20, ack); send_byte(8'h55, ack);
    bus_stop();
    bus_start();
    send_byte(8'hB0, ack);
    chk(!ack, "R2 bad id 0xB0 not acked", int'(ack), 0);
    bus_stop();
    chk(wr_cnt == base, "R2 ignored bytes issue no write", wr_cnt, base);
    read_one(d, ack, st);
    bus_stop();
    chk(d == model_rd(15'h2AAC, 0), "R2 pointer untouched", int'(d), int'(model_rd(15'h2AAC, 0)));

    // Busy committer refuses addresses.
    wr_busy = 1'b1;
    bus_start();
    send_byte(8'hA0, ack);
    bus_stop();
    chk(!ack, "R3 busy refuses write header", int'(ack), 0);
    bus_start();
    send_byte(8'hA1, ack);
    bus_stop();
    chk(!ack, "R3 busy refuses read header", int'(ack), 0);
    wr_busy = 1'b0;
    read_one(d, ack, st);
    bus_stop();
    chk(ack, "R3 ack returns when idle", int'(ack), 1);

    // Page rollover during a multi-byte write.
    base = wr_cnt;
    write_hdr(8'h01, 8'h3E, ok);
    send_byte(8'h11, ack); send_byte(8'h22, ack); send_byte(8'h33, ack);
    bus_stop();
    chk(wr_cnt == base + 3 && wr_log_a[base[5:0] + 6'd1] == 15'h013F,
        "R5 second write address", int'(wr_log_a[base[5:0] + 6'd1]), 'h013F);
    chk(wr_log_a[base[5:0] + 6'd2] == 15'h0100, "R5 page rollover",
        int'(wr_log_a[base[5:0] + 6'd2]), 'h0100);

    // Sequential read across the top of the array.
    write_hdr(8'h7F, 8'hFE, ok);
    bus_start();
    send_byte(8'hA1, ack);
    recv_byte(1'b1, d, st);
    chk(d == model_rd(15'h7FFE, 0), "R8 seq byte 0", int'(d), int'(model_rd(15'h7FFE, 0)));
    recv_byte(1'b1, d, st);
    chk(d == 8'h96, "R8 seq byte 1", int'(d), 'h96);
    recv_byte(1'b0, d, st);
    bus_stop();
    chk(d == model_rd(15'h0000, 0), "R8 wrap to zero", int'(d), int'(model_rd(15'h0000, 0)));

    // Start in the middle of a data byte.
    base = wr_cnt;
    write_hdr(8'h05, 8'h00, ok);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_start();
    send_byte(8'hA1, ack);
    recv_byte(1'b0, d, st);
    bus_stop();
    chk(wr_cnt == base, "R11 aborted byte not written", wr_cnt, base);
    chk(ack && d == model_rd(15'h0500, 0), "R11 new header accepted",
        int'(d), int'(model_rd(15'h0500, 0)));

    // Stop in the middle of a data byte.
    base = wr_cnt;
    write_hdr(8'h06, 8'h00, ok);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_stop();
    chk(wr_cnt == base && sda_line == 1'b1, "R1 stop mid-byte discards", wr_cnt, base);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end
endmodule